// File: doc/BRIEF.md
# Ring-Chained FIFO Slice

This block is one slice of a buffer that can be made deeper by chaining several identical slices in a ring. Every slice sees the same write strobe, read strobe and write data. The expansion output of each slice is wired to the expansion input of the next slice, and the output of the last slice returns to the first. One slice has its first-load input tied low. After reset, that slice owns the right to accept writes (the write token) and the right to supply reads (the read token). A slice fills its local storage from address 0 up to address DEPTH-1. When it writes that top address, it passes the write token on with a one-cycle low pulse on its expansion output. When it reads that top address, it passes the read token on the same way. Only the slice that holds a token acts on the matching strobe, so the chain behaves as one FIFO of DEPTH x slices words.

The slice samples its configuration while reset is high. If the expansion input is low and first-load is high, the slice runs standalone. It then holds both tokens for good, and its expansion output shows a half-full flag. Each slice reports its own full and empty flags, qualified by token ownership, so that OR-ing the flags of all slices gives the full and empty state of the whole chain. Read data comes from a registered output and is qualified by a drive signal. The data lines of a slice are zero whenever that slice is not driving, so the chain's read bus is the OR of all slices.

Top module: `ring_fifo_slice`

## Requirements
- R1: While `rst` is high, the slice selects standalone mode if `exp_in_n`=0 and `first_n`=1, and ring mode otherwise. The mode is held until the next reset. A standalone slice behaves as a plain FIFO of DEPTH words, with `slice_full` high at DEPTH stored words and `slice_empty` high at zero stored words.
- R2: After reset in ring mode, the slice with `first_n`=0 holds both tokens and the other slices hold none. On an empty chain, only the first slice reports `slice_empty`=1, and no slice reports `slice_full`.
- R3: Data written to the chain is read back in the order it was written, across slice boundaries and over any number of laps around the ring.
- R4: In ring mode, `exp_out_n` is low for the single cycle after the slice accepts a write to its local address DEPTH-1. The slice then stops accepting writes until the write token returns.
- R5: In ring mode, `exp_out_n` is low for the single cycle after the slice accepts a read of its local address DEPTH-1. The slice then stops supplying reads until the read token returns.
- R6: `slice_full` is high when the slice holds the write token and all DEPTH of its locations are unread. A write strobe in that state is ignored, so a full chain drops the write.
- R7: `slice_empty` is high when the slice holds the read token and it has no unread word. A read strobe in that state is ignored and produces no drive.
- R8: A read that is accepted on one clock edge sets `rd_drive` high for the next cycle, with the word on `rd_data`. In all other cycles `rd_drive` is 0 and `rd_data` is all zeros.
- R9: In standalone mode, `exp_out_n` acts as an active-low half-full flag. It is 0 while more than DEPTH/2 words are stored.
- R10: A token pulse arriving on `exp_in_n` lets the slice act on a strobe in that same cycle, so back-to-back strobes across a slice boundary are never lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is sampled while it is high |
| first_n | input | 1 | Low on the slice that owns both tokens after reset |
| exp_in_n | input | 1 | Token pulse from the previous slice; tie low for standalone |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | WIDTH | Shared write data |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | WIDTH | Read word; zero when not driving |
| rd_drive | output | 1 | High in the cycle this slice presents a read word |
| slice_full | output | 1 | Slice holds the write token and has no free location |
| slice_empty | output | 1 | Slice holds the read token and has no unread word |
| exp_out_n | output | 1 | Ring mode: token-pass pulse; standalone: half-full, active low |

## Verification
The hardest case to reach is the wrap-around of the write token. A slice that still holds the read token and has unread data gets the write token back, and its own flags then have to track the state of the whole chain. The bench reaches this case by filling a three-slice ring completely, draining it, and then running long stretches of random traffic. This traffic carries both pointers several laps around the ring, with reads and writes hitting the same clock edges. On every clock, the reference model predicts which slice owns each token, which slice pulses its expansion output, and which slice drives the read bus.

// File: rtl/ring_slice_pkg.sv
package ring_slice_pkg;

  typedef enum logic {
    SLICE_SOLO = 1'b0,
    SLICE_RING = 1'b1
  } slice_mode_e;

  // Standalone only when expansion-in is strapped low and first-load is high.
  function automatic slice_mode_e pick_mode(input logic exp_in_n, input logic first_n);
    return (!exp_in_n && first_n) ? SLICE_SOLO : SLICE_RING;
  endfunction

endpackage

// File: rtl/slice_ram.sv
module slice_ram #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [$clog2(DEPTH)-1:0]   waddr,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       re,
  input  logic [$clog2(DEPTH)-1:0]   raddr,
  output logic [WIDTH-1:0]           rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/slice_ptrs.sv
module slice_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_req,
  input  logic                       rd_req,
  input  logic                       have_w,
  input  logic                       have_r,
  output logic                       do_wr,
  output logic                       do_rd,
  output logic [$clog2(DEPTH)-1:0]   waddr,
  output logic [$clog2(DEPTH)-1:0]   raddr,
  output logic                       w_last,
  output logic                       r_last,
  output logic                       full_cnt,
  output logic                       empty_cnt,
  output logic                       hf_next
);

  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [CW-1:0] cnt, cnt_next;

  assign full_cnt  = (cnt == CW'(DEPTH));
  assign empty_cnt = (cnt == '0);
  assign do_wr     = wr_req & have_w & ~full_cnt;
  assign do_rd     = rd_req & have_r & ~empty_cnt;
  assign w_last    = do_wr & (waddr == TOP);
  assign r_last    = do_rd & (raddr == TOP);
  assign cnt_next  = cnt + CW'(do_wr) - CW'(do_rd);
  assign hf_next   = (cnt_next > CW'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      waddr <= '0;
      raddr <= '0;
    end else begin
      cnt <= cnt_next;
      if (do_wr) waddr <= (waddr == TOP) ? '0 : waddr + AW'(1);
      if (do_rd) raddr <= (raddr == TOP) ? '0 : raddr + AW'(1);
    end
  end

  initial assert (DEPTH >= 2 && (1 << AW) == DEPTH)
    else $error("slice depth must be a power of two");

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_full_holds_wptr_R6: assert property (@(posedge clk) disable iff (rst)
    (full_cnt && !do_rd) |=> $stable(waddr));

  assert_empty_holds_rptr_R7: assert property (@(posedge clk) disable iff (rst)
    (empty_cnt && !do_wr) |=> $stable(raddr));

endmodule

// File: rtl/slice_token_ctrl.sv
module slice_token_ctrl
  import ring_slice_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic first_n,
  input  logic exp_in_n,
  input  logic w_last,
  input  logic r_last,
  input  logic hf_next,
  output logic have_w,
  output logic have_r,
  output logic exp_out_n
);

  slice_mode_e mode_q, mode_sel;
  logic        wr_tok, rd_tok, expect_w, xo_q;
  logic        is_ring, in_pulse;

  assign mode_sel = pick_mode(exp_in_n, first_n);
  assign is_ring  = (mode_q == SLICE_RING);
  assign in_pulse = is_ring & ~exp_in_n;

  // Tokens reach a slice alternately, write first, so one toggle names the pulse.
  assign have_w    = wr_tok | (in_pulse & expect_w);
  assign have_r    = rd_tok | (in_pulse & ~expect_w);
  assign exp_out_n = xo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= mode_sel;
      wr_tok   <= (mode_sel == SLICE_SOLO) | ~first_n;
      rd_tok   <= (mode_sel == SLICE_SOLO) | ~first_n;
      expect_w <= 1'b1;
      xo_q     <= 1'b1;
    end else if (is_ring) begin
      wr_tok <= have_w & ~w_last;
      rd_tok <= have_r & ~r_last;
      if (in_pulse) expect_w <= ~expect_w;
      xo_q <= ~(w_last | r_last);
    end else begin
      xo_q <= ~hf_next;
    end
  end

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

  assert_single_handoff_R5: assert property (@(posedge clk) disable iff (rst)
    is_ring |-> !(w_last && r_last));

  assert_wtok_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (is_ring && w_last) |=> !wr_tok);

  assert_rtok_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (is_ring && r_last) |=> !rd_tok);

endmodule

// File: rtl/ring_fifo_slice.sv
module ring_fifo_slice #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_n,
  input  logic             exp_in_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_drive,
  output logic             slice_full,
  output logic             slice_empty,
  output logic             exp_out_n
);

  localparam int AW = $clog2(DEPTH);

  logic          have_w, have_r, do_wr, do_rd, w_last, r_last;
  logic          full_cnt, empty_cnt, hf_next;
  logic [AW-1:0] waddr, raddr;
  logic [WIDTH-1:0] q;

  slice_token_ctrl u_tok (
    .clk       (clk),
    .rst       (rst),
    .first_n   (first_n),
    .exp_in_n  (exp_in_n),
    .w_last    (w_last),
    .r_last    (r_last),
    .hf_next   (hf_next),
    .have_w    (have_w),
    .have_r    (have_r),
    .exp_out_n (exp_out_n)
  );

  slice_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_en),
    .rd_req    (rd_en),
    .have_w    (have_w),
    .have_r    (have_r),
    .do_wr     (do_wr),
    .do_rd     (do_rd),
    .waddr     (waddr),
    .raddr     (raddr),
    .w_last    (w_last),
    .r_last    (r_last),
    .full_cnt  (full_cnt),
    .empty_cnt (empty_cnt),
    .hf_next   (hf_next)
  );

  slice_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (do_wr),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (do_rd),
    .raddr (raddr),
    .rdata (q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_drive <= 1'b0;
    else     rd_drive <= do_rd;
  end

  assign rd_data     = rd_drive ? q : '0;
  assign slice_full  = have_w & full_cnt;
  assign slice_empty = have_r & empty_cnt;

  assert_drive_after_read_R8: assert property (@(posedge clk) disable iff (rst)
    rd_drive |-> $past(rd_en));

endmodule

// File: tb/test_ring_fifo_slice.sv
module test_ring_fifo_slice;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 9;
  localparam int D   = 8;
  localparam int N   = 3;
  localparam int CAP = D * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;

  logic [N-1:0] xo_n, full_v, empty_v, drv_v;
  logic [W-1:0] rdat [N];

  logic [W-1:0] s_rdat;
  logic s_drv, s_full, s_empty, s_xo;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar s = 0; s < N; s++) begin : g_slice
    ring_fifo_slice #(.WIDTH(W), .DEPTH(D)) i_ring_fifo_slice (
      .clk        (clk),
      .rst        (rst),
      .first_n    ((s == 0) ? 1'b0 : 1'b1),
      .exp_in_n   (xo_n[(s + N - 1) % N]),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_en      (rd_en),
      .rd_data    (rdat[s]),
      .rd_drive   (drv_v[s]),
      .slice_full (full_v[s]),
      .slice_empty(empty_v[s]),
      .exp_out_n  (xo_n[s])
    );
  end

  ring_fifo_slice #(.WIDTH(W), .DEPTH(D)) i_ring_fifo_slice (
    .clk        (clk),
    .rst        (rst),
    .first_n    (1'b1),
    .exp_in_n   (1'b0),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (s_rdat),
    .rd_drive   (s_drv),
    .slice_full (s_full),
    .slice_empty(s_empty),
    .exp_out_n  (s_xo)
  );

  // Reference state
  logic [W-1:0] q[$];
  logic [W-1:0] sq[$];
  int wcnt = 0, rcnt = 0;
  bit [N-1:0] exp_xo_low = '0;
  bit exp_drv = 0, s_exp_drv = 0;
  logic [W-1:0] exp_dat = '0, s_exp_dat = '0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] bus;
    int wsl, rsl;
    bus = '0;
    for (int s = 0; s < N; s++) bus |= rdat[s];
    wsl = (wcnt / D) % N;
    rsl = (rcnt / D) % N;
    for (int s = 0; s < N; s++) begin
      chk($sformatf("R6 slice %0d full", s), full_v[s],
          (s == wsl && q.size() == CAP) ? 1 : 0);
      chk($sformatf("R7 slice %0d empty", s), empty_v[s],
          (s == rsl && q.size() == 0) ? 1 : 0);
      chk($sformatf("R4 R5 slice %0d exp_out_n", s), xo_n[s], exp_xo_low[s] ? 0 : 1);
    end
    chk("R8 ring drive count", $countones(drv_v), exp_drv ? 1 : 0);
    if (exp_drv) chk("R3 ring read word", bus, exp_dat);
    else         chk("R8 ring bus idle", bus, 0);
    chk("R1 solo full", s_full, (sq.size() == D) ? 1 : 0);
    chk("R1 solo empty", s_empty, (sq.size() == 0) ? 1 : 0);
    chk("R9 solo half-full", s_xo, (sq.size() > D/2) ? 0 : 1);
    chk("R8 solo drive", s_drv, s_exp_drv ? 1 : 0);
    chk("R8 solo word", s_rdat, s_exp_drv ? s_exp_dat : 0);
  endtask

  task automatic cycle(input bit w, input bit r);
    bit wacc, racc, swacc, sracc;
    logic [W-1:0] d;
    @(negedge clk);
    check_all();
    d = W'($urandom);
    wr_en = w; rd_en = r; wr_data = d;
    wacc  = w && q.size() < CAP;
    racc  = r && q.size() > 0;
    swacc = w && sq.size() < D;
    sracc = r && sq.size() > 0;
    exp_xo_low = '0;
    exp_drv = racc;
    s_exp_drv = sracc;
    if (racc) begin
      exp_dat = q.pop_front();
      if (rcnt % D == D - 1) exp_xo_low[(rcnt / D) % N] = 1'b1;
      rcnt++;
    end
    if (wacc) begin
      q.push_back(d);
      if (wcnt % D == D - 1) exp_xo_low[(wcnt / D) % N] = 1'b1;
      wcnt++;
    end
    if (sracc) s_exp_dat = sq.pop_front();
    if (swacc) sq.push_back(d);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: only the first-load slice owns the read token on an empty chain
    chk("R2 reset empty flags", empty_v, 3'b001);
    chk("R2 reset full flags", full_v, 0);
    chk("R2 reset exp_out_n", xo_n, 3'b111);
    chk("R1 solo reset empty", s_empty, 1);

    for (int i = 0; i < CAP + 2; i++) cycle(1, 0);
    @(negedge clk);
    chk("R10 chain full after back-to-back writes", |full_v, 1);
    for (int i = 0; i < CAP + 2; i++) cycle(0, 1);
    for (int i = 0; i < 4; i++) cycle(1, 1);
    for (int i = 0; i < 500; i++) cycle(($urandom % 10) < 6, ($urandom % 10) < 5);
    for (int i = 0; i < 300; i++) cycle(($urandom % 10) < 3, ($urandom % 10) < 8);
    for (int i = 0; i < 300; i++) cycle(($urandom % 10) < 8, ($urandom % 10) < 3);
    for (int i = 0; i < 200; i++) cycle(1, 1);
    for (int i = 0; i < CAP + 4; i++) cycle(0, 1);
    cycle(0, 0);
    cycle(0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule